// File: doc/BRIEF.md
# Vector Compare to Predicate Mask Unit

This unit compares two operand streams element by element and packs the outcomes into a predicate bitmask. The mask is meant to land in an ordinary integer register, where later vector operations can use it to enable or skip elements. Each operand names a base register and carries a configured length. An operand whose length is above one is a vector, and element i of it comes from register base+i. Otherwise the operand is a scalar, and its one register is reused for every element.

One start pulse runs a whole operation. The unit presents one pair of read indices per cycle to an external register file that reads combinationally. It collects one mask bit per element and then hands out the finished mask with a single write strobe. When both operands are scalar, no mask is built. The unit instead makes a single compare and reports it as a taken or not-taken conditional branch decision, which the fetch logic outside acts on.

Top module: `vcmp_mask_top`

## Requirements
- R1: After reset the unit is idle: `busy`, `maskWe` and `branchValid` are 0 and `maskOut` is 0.
- R2: An operand is a vector when its length input is 2 or more. A length of 0 or 1 makes it a scalar.
- R3: With a start accepted at clock edge E, element i (i = 0 .. VL-1) is read in the cycle after edge E+i. A vector operand presents index base+i, modulo 2^IDX_W. A scalar operand presents its base index.
- R4: `cmpSel` encodings: 0 equal, 1 not equal, 2 signed less-than, 3 signed greater-or-equal, 4 unsigned less-than, 5 unsigned greater-or-equal. Codes 6 and 7 never match. The test is operand 1 against operand 2, both latched at start.
- R5: Bit i of the written mask is the compare result of element i. Every bit at position VL or above is 0, because the mask is cleared when an operation starts.
- R6: `maskWe` is high for exactly one cycle, the cycle after the last element read, and `maskOut` holds the mask during it. With VL = 0 that is the cycle after the start edge, and the mask is zero.
- R7: When both operands are scalar, `branchValid` is high for one cycle, the cycle after the start edge. In that cycle `branchTaken` equals the compare result. `maskWe` is not raised for that operation.
- R8: A start that arrives while `busy` is high is ignored. The running operation's indices, mask and timing are unchanged.
- R9: A VL input above MAX_VL is treated as MAX_VL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset, synchronous |
| start | input | 1 | Begin an operation (taken only when idle) |
| cmpSel | input | 3 | Compare type code |
| vlIn | input | VLW | Element count of the operation |
| src1Base | input | IDX_W | Base register of operand 1 |
| src1Len | input | VLW | Configured length of operand 1 |
| src2Base | input | IDX_W | Base register of operand 2 |
| src2Len | input | VLW | Configured length of operand 2 |
| rdIdx1 | output | IDX_W | Register read index for operand 1 |
| rdData1 | input | DATA_W | Register value at rdIdx1 (same cycle) |
| rdIdx2 | output | IDX_W | Register read index for operand 2 |
| rdData2 | input | DATA_W | Register value at rdIdx2 (same cycle) |
| busy | output | 1 | Operation in progress |
| maskOut | output | MAX_VL | Predicate mask to be written |
| maskWe | output | 1 | One-cycle write strobe for maskOut |
| branchValid | output | 1 | Branch decision present (both operands scalar) |
| branchTaken | output | 1 | Branch decision outcome |

## Verification
The bench uses the default parameters: 32-bit elements, MAX_VL of 8 and 5-bit register indices. A 4-bit VL field can then ask for up to 15 elements, so the clamp at 8 can be driven, and a full 8-bit mask is reachable. A vector based at register 28 walks past index 31 and back to 0, which exercises the index wrap. The register model mixes negative and positive values with a few equal pairs. This lets signed and unsigned orderings give different masks, and lets equality hit on selected elements.

// File: rtl/vcmp_pkg.sv
package vcmp_pkg;
  localparam logic [2:0] CMP_EQ  = 3'd0;
  localparam logic [2:0] CMP_NE  = 3'd1;
  localparam logic [2:0] CMP_LTS = 3'd2;
  localparam logic [2:0] CMP_GES = 3'd3;
  localparam logic [2:0] CMP_LTU = 3'd4;
  localparam logic [2:0] CMP_GEU = 3'd5;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_WRITE, ST_BRANCH} ctrlState_e;

  typedef struct packed {
    logic load;
    logic accum;
    logic writeMask;
    logic branch;
  } ctrlStrobe_t;
endpackage

// File: rtl/vcmp_compare.sv
module vcmp_compare #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [2:0]        sel,
  output logic              hit
);
  import vcmp_pkg::*;

  logic eqBit, ltsBit, ltuBit;

  always_comb begin
    eqBit  = (opA == opB);
    ltsBit = ($signed(opA) < $signed(opB));
    ltuBit = (opA < opB);
    case (sel)
      CMP_EQ:  hit = eqBit;
      CMP_NE:  hit = !eqBit;
      CMP_LTS: hit = ltsBit;
      CMP_GES: hit = !ltsBit;
      CMP_LTU: hit = ltuBit;
      CMP_GEU: hit = !ltuBit;
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/vcmp_ctrl.sv
module vcmp_ctrl #(
  parameter int MAX_VL = 8,
  localparam int VLW = $clog2(MAX_VL + 1)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  start,
  input  logic [VLW-1:0]        vlIn,
  input  logic                  bothScalar,
  output vcmp_pkg::ctrlStrobe_t strobe,
  output logic [VLW-1:0]        elemIdx,
  output logic                  busy
);
  import vcmp_pkg::*;

  ctrlState_e state, stateNext;
  logic [VLW-1:0] vlReg;
  logic [VLW-1:0] vlClamped;
  logic           lastElem;

  always_comb begin
    vlClamped = (vlIn > VLW'(MAX_VL)) ? VLW'(MAX_VL) : vlIn;
    lastElem  = (elemIdx == VLW'(vlReg - VLW'(1)));
  end

  always_comb begin
    strobe    = '0;
    stateNext = state;
    case (state)
      ST_IDLE: begin
        if (start) begin
          strobe.load = 1'b1;
          if (bothScalar)                stateNext = ST_BRANCH;
          else if (vlClamped == '0)      stateNext = ST_WRITE;
          else                           stateNext = ST_RUN;
        end
      end
      ST_RUN: begin
        strobe.accum = 1'b1;
        if (lastElem) stateNext = ST_WRITE;
      end
      ST_WRITE: begin
        strobe.writeMask = 1'b1;
        stateNext = ST_IDLE;
      end
      ST_BRANCH: begin
        strobe.branch = 1'b1;
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      vlReg   <= '0;
      elemIdx <= '0;
    end else begin
      state <= stateNext;
      if (strobe.load) begin
        vlReg   <= vlClamped;
        elemIdx <= '0;
      end else if (strobe.accum && !lastElem) begin
        elemIdx <= elemIdx + VLW'(1);
      end
    end
  end

  assign busy = (state != ST_IDLE);

  // R6, R9: element counter stays inside the clamped length
  a_r6_run_bound: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN) |-> (elemIdx < vlReg && vlReg <= VLW'(MAX_VL)));

  // R6: write strobe lasts one cycle
  a_r6_single_write: assert property (@(posedge clk) disable iff (!rstN)
    strobe.writeMask |=> !strobe.writeMask);
endmodule

// File: rtl/vcmp_dpath.sv
module vcmp_dpath #(
  parameter int DATA_W = 32,
  parameter int MAX_VL = 8,
  parameter int IDX_W  = 5,
  localparam int VLW = $clog2(MAX_VL + 1)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  vcmp_pkg::ctrlStrobe_t strobe,
  input  logic [VLW-1:0]        elemIdx,
  input  logic [2:0]            cmpSel,
  input  logic [IDX_W-1:0]      src1Base,
  input  logic [VLW-1:0]        src1Len,
  input  logic [IDX_W-1:0]      src2Base,
  input  logic [VLW-1:0]        src2Len,
  input  logic [DATA_W-1:0]     rdData1,
  input  logic [DATA_W-1:0]     rdData2,
  output logic                  bothScalar,
  output logic [IDX_W-1:0]      rdIdx1,
  output logic [IDX_W-1:0]      rdIdx2,
  output logic [MAX_VL-1:0]     maskOut,
  output logic                  maskWe,
  output logic                  branchValid,
  output logic                  branchTaken
);
  logic [IDX_W-1:0]  base1, base2;
  logic              vec1, vec2;
  logic [2:0]        opReg;
  logic              hit;
  logic [MAX_VL-1:0] mask;
  logic [IDX_W-1:0]  offset;

  assign bothScalar = (src1Len < VLW'(2)) && (src2Len < VLW'(2));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      base1 <= '0;
      base2 <= '0;
      vec1  <= 1'b0;
      vec2  <= 1'b0;
      opReg <= '0;
    end else if (strobe.load) begin
      base1 <= src1Base;
      base2 <= src2Base;
      vec1  <= (src1Len > VLW'(1));
      vec2  <= (src2Len > VLW'(1));
      opReg <= cmpSel;
    end
  end

  always_comb begin
    offset = IDX_W'(elemIdx);
    rdIdx1 = vec1 ? IDX_W'(base1 + offset) : base1;
    rdIdx2 = vec2 ? IDX_W'(base2 + offset) : base2;
  end

  vcmp_compare #(.DATA_W(DATA_W)) u_cmp (
    .opA(rdData1),
    .opB(rdData2),
    .sel(opReg),
    .hit(hit)
  );

  for (genvar g = 0; g < MAX_VL; g++) begin : g_maskBit
    always_ff @(posedge clk) begin
      if (!rstN || strobe.load)
        mask[g] <= 1'b0;
      else if (strobe.accum && elemIdx == VLW'(g))
        mask[g] <= hit;
    end
  end

  assign maskOut     = mask;
  assign maskWe      = strobe.writeMask;
  assign branchValid = strobe.branch;
  assign branchTaken = strobe.branch & hit;

  // R3: a scalar operand keeps one index across consecutive elements
  a_r3_scalar_hold: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.accum && $past(strobe.accum) && !vec1) |-> $stable(rdIdx1));

  // R3: a vector operand steps its index by one per element
  a_r3_vector_step: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.accum && $past(strobe.accum) && vec2) |->
      (rdIdx2 == IDX_W'($past(rdIdx2) + 1'b1)));
endmodule

// File: rtl/vcmp_mask_top.sv
module vcmp_mask_top #(
  parameter int DATA_W = 32,
  parameter int MAX_VL = 8,
  parameter int IDX_W  = 5,
  localparam int VLW = $clog2(MAX_VL + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [2:0]        cmpSel,
  input  logic [VLW-1:0]    vlIn,
  input  logic [IDX_W-1:0]  src1Base,
  input  logic [VLW-1:0]    src1Len,
  input  logic [IDX_W-1:0]  src2Base,
  input  logic [VLW-1:0]    src2Len,
  output logic [IDX_W-1:0]  rdIdx1,
  input  logic [DATA_W-1:0] rdData1,
  output logic [IDX_W-1:0]  rdIdx2,
  input  logic [DATA_W-1:0] rdData2,
  output logic              busy,
  output logic [MAX_VL-1:0] maskOut,
  output logic              maskWe,
  output logic              branchValid,
  output logic              branchTaken
);
  vcmp_pkg::ctrlStrobe_t strobe;
  logic [VLW-1:0] elemIdx;
  logic           bothScalar;

  vcmp_ctrl #(.MAX_VL(MAX_VL)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .vlIn(vlIn),
    .bothScalar(bothScalar), .strobe(strobe), .elemIdx(elemIdx), .busy(busy)
  );

  vcmp_dpath #(.DATA_W(DATA_W), .MAX_VL(MAX_VL), .IDX_W(IDX_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .elemIdx(elemIdx),
    .cmpSel(cmpSel), .src1Base(src1Base), .src1Len(src1Len),
    .src2Base(src2Base), .src2Len(src2Len),
    .rdData1(rdData1), .rdData2(rdData2), .bothScalar(bothScalar),
    .rdIdx1(rdIdx1), .rdIdx2(rdIdx2), .maskOut(maskOut), .maskWe(maskWe),
    .branchValid(branchValid), .branchTaken(branchTaken)
  );

  // R7: a branch decision and a mask write never share a cycle
  a_r7_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(maskWe && branchValid));

  // R6, R7: the unit is idle again right after either result
  a_r6_idle_after: assert property (@(posedge clk) disable iff (!rstN)
    (maskWe || branchValid) |=> !busy);
endmodule

// File: tb/tb_vcmp_mask_top.sv
module tb_vcmp_mask_top;
  localparam int DATA_W = 32;
  localparam int MAX_VL = 8;
  localparam int IDX_W  = 5;
  localparam int VLW    = $clog2(MAX_VL + 1);
  localparam int NREG   = 1 << IDX_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [2:0] cmpSel = '0;
  logic [VLW-1:0] vlIn = '0;
  logic [IDX_W-1:0] src1Base = '0, src2Base = '0;
  logic [VLW-1:0] src1Len = '0, src2Len = '0;
  logic [IDX_W-1:0] rdIdx1, rdIdx2;
  logic [DATA_W-1:0] rdData1, rdData2;
  logic busy, maskWe, branchValid, branchTaken;
  logic [MAX_VL-1:0] maskOut;

  logic [DATA_W-1:0] regs [NREG];
  int nChecks = 0;
  int nFails = 0;

  always #2.5 clk = ~clk;

  always_comb begin
    rdData1 = regs[rdIdx1];
    rdData2 = regs[rdIdx2];
  end

  vcmp_mask_top #(.DATA_W(DATA_W), .MAX_VL(MAX_VL), .IDX_W(IDX_W)) dut (
    .clk(clk), .rstN(rstN), .start(start), .cmpSel(cmpSel), .vlIn(vlIn),
    .src1Base(src1Base), .src1Len(src1Len), .src2Base(src2Base), .src2Len(src2Len),
    .rdIdx1(rdIdx1), .rdData1(rdData1), .rdIdx2(rdIdx2), .rdData2(rdData2),
    .busy(busy), .maskOut(maskOut), .maskWe(maskWe),
    .branchValid(branchValid), .branchTaken(branchTaken)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit cmpRef(input int op, input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] b);
    case (op)
      0: return a == b;
      1: return a != b;
      2: return $signed(a) < $signed(b);
      3: return $signed(a) >= $signed(b);
      4: return a < b;
      5: return a >= b;
      default: return 1'b0;
    endcase
  endfunction

  // One full operation; glitchAt >= 0 pulses start again during element glitchAt
  task automatic runOp(input int op, input int vl, input int b1, input int l1,
                       input int b2, input int l2, input int glitchAt, input string tag);
    int effVl;
    bit s1, s2;
    logic [MAX_VL-1:0] expMask;
    int i1, i2;
    effVl = (vl > MAX_VL) ? MAX_VL : vl;
    s1 = (l1 <= 1);
    s2 = (l2 <= 1);
    expMask = '0;
    @(negedge clk);
    start = 1'b1; cmpSel = 3'(op); vlIn = VLW'(vl);
    src1Base = IDX_W'(b1); src1Len = VLW'(l1);
    src2Base = IDX_W'(b2); src2Len = VLW'(l2);
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    if (s1 && s2) begin
      chk(branchValid == 1'b1, {tag, " R7 branchValid"}, branchValid, 1);
      chk(branchTaken == cmpRef(op, regs[b1], regs[b2]), {tag, " R7 branchTaken"},
          branchTaken, cmpRef(op, regs[b1], regs[b2]));
      chk(maskWe == 1'b0, {tag, " R7 no mask write"}, maskWe, 0);
      @(negedge clk);
      chk(!branchValid && !busy && !maskWe, {tag, " R7 one cycle"}, {branchValid, busy, maskWe}, 0);
      return;
    end
    for (int i = 0; i < effVl; i++) begin
      start = 1'b0;
      i1 = s1 ? b1 : (b1 + i) % NREG;
      i2 = s2 ? b2 : (b2 + i) % NREG;
      chk(rdIdx1 == IDX_W'(i1), {tag, " R3 rdIdx1"}, rdIdx1, i1);
      chk(rdIdx2 == IDX_W'(i2), {tag, " R3 rdIdx2"}, rdIdx2, i2);
      chk(maskWe == 1'b0 && busy, {tag, " R6 no early strobe"}, maskWe, 0);
      expMask[i] = cmpRef(op, regs[i1], regs[i2]);
      if (i == glitchAt) begin
        start = 1'b1; cmpSel = 3'(op ^ 1); vlIn = VLW'(1);
        src1Len = '0; src2Len = '0; src1Base = '0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    chk(maskWe == 1'b1, {tag, " R6 strobe"}, maskWe, 1);
    chk(maskOut == expMask, {tag, " R4/R5 mask"}, maskOut, expMask);
    chk(branchValid == 1'b0, {tag, " R7 no branch"}, branchValid, 0);
    @(negedge clk);
    chk(!maskWe && !busy, {tag, " R6 single strobe"}, {maskWe, busy}, 0);
  endtask

  task automatic testReset();
    chk(!busy && !maskWe && !branchValid && maskOut == '0, "R1 reset state",
        {busy, maskWe, branchValid, maskOut}, 0);
  endtask

  task automatic testAllCodes();
    for (int op = 0; op < 8; op++) runOp(op, 8, 2, 8, 10, 8, -1, "R4 vec-vec");
  endtask

  task automatic testMixed();
    runOp(2, 6, 28, 4, 5, 1, -1, "R2 R3 wrap vs scalar len1");
    runOp(4, 5, 3, 0, 12, 6, -1, "R2 scalar len0 vs vec");
  endtask

  task automatic testClear();
    runOp(0, 8, 4, 8, 4, 8, -1, "R5 all ones");
    runOp(0, 3, 4, 8, 4, 8, -1, "R5 short clears upper");
  endtask

  task automatic testZeroAndClamp();
    runOp(0, 0, 4, 8, 4, 8, -1, "R6 VL zero");
    runOp(3, 12, 1, 9, 20, 9, -1, "R9 clamp");
  endtask

  task automatic testBranch();
    runOp(0, 4, 4, 1, 12, 0, -1, "R7 eq");
    runOp(1, 4, 4, 1, 12, 1, -1, "R7 ne");
    runOp(2, 4, 3, 0, 5, 0, -1, "R7 lts");
    runOp(4, 4, 3, 1, 5, 1, -1, "R7 ltu");
  endtask

  task automatic testBusyStart();
    runOp(2, 7, 1, 8, 9, 8, 2, "R8 start while busy");
  endtask

  initial begin
    for (int k = 0; k < NREG; k++)
      regs[k] = (k % 3 == 0) ? DATA_W'(-(k + 1)) : DATA_W'(k * 5);
    regs[12] = regs[4];
    regs[15] = regs[7];
    regs[20] = regs[1];
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testAllCodes();
    testMixed();
    testClear();
    testZeroAndClamp();
    testBranch();
    testBusyStart();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule